// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of stack-oriented instructions against a word-addressed data memory. Only two instructions touch memory: a load that copies one memory word onto an internal operand stack, and a store that moves the stack's top entry out to memory. The arithmetic instructions carry no operand fields at all. Each one consumes the two topmost stack entries and leaves a single result on top.

A postfix expression therefore maps directly onto an instruction sequence. The surrounding logic presents one instruction at a time through a valid/ready handshake. It also provides a synchronous memory with one cycle of read latency.

Error conditions do not stop the unit. Overflow, underflow and divide-by-zero each raise a sticky flag, and the offending instruction has no effect on the stack beyond what the requirements state. A halt instruction freezes the unit until reset.

Top module: `zstack_exec_unit`

## Requirements
- R1: After a synchronous active-high reset the stack is empty, all three flags and `halted` are low, and `instr_ready` is high.
- R2: The instruction word is `{opcode[2:0], address[ADDR_W-1:0]}` with opcodes 0 no-op, 1 load (push from memory), 2 store (pop to memory), 3 add, 4 subtract, 5 multiply, 6 divide, 7 halt. A load raises `mem_rd_en` with `mem_addr` equal to the address in its accept cycle, pushes `mem_rdata` one cycle later, and holds `instr_ready` low during that second cycle.
- R3: A store on a non-empty stack raises `mem_wr_en` in its accept cycle, with the top entry on `mem_wdata` and the address on `mem_addr`, and removes that entry.
- R4: Add, subtract and multiply take the deeper of the two top entries as the left operand and the top entry as the right operand. They replace both entries with one result, modulo 2^DATA_W; multiply keeps the low DATA_W bits.
- R5: Divide gives the unsigned quotient of left by right. When the right operand is zero it pushes 0 and sets the sticky divide-by-zero flag.
- R6: A load on a full stack (DEPTH entries) sets the sticky overflow flag, issues no memory read and leaves the stack unchanged.
- R7: A store on an empty stack, or an arithmetic instruction with fewer than two entries, sets the sticky underflow flag, issues no memory write and leaves the stack unchanged.
- R8: Halt raises `halted` and keeps `instr_ready` low until reset; while halted no memory access happens.
- R9: The sequence load X, load Y, multiply, load W, load U, multiply, add, store Z writes X*Y+W*U to Z.
- R10: A no-op leaves the stack and flags unchanged, and a set flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_word | input | 3+ADDR_W | Opcode and address |
| mem_addr | output | ADDR_W | Data memory address |
| mem_rd_en | output | 1 | Memory read strobe; data returns next cycle |
| mem_rdata | input | DATA_W | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Write data |
| halted | output | 1 | Unit has executed halt |
| ovf_flag | output | 1 | Sticky stack overflow |
| unf_flag | output | 1 | Sticky stack underflow |
| dz_flag | output | 1 | Sticky divide by zero |

## Verification
Two functions can fall in the same cycle in this block.

The first pair is a load arriving at a full stack. In that one accept cycle the overflow flag must rise and the memory read must be suppressed. The bench fills the stack to DEPTH entries, offers a ninth load from an address holding a distinct value, and then drains the stack. The drain must return the eight pushed values in reverse order, with the flag set and the ninth value absent.

The second pair is halt and a pending instruction. A load is held valid after halt, and the bench confirms that no memory strobe appears and that `instr_ready` stays low.

// File: rtl/zsx_pkg.sv
package zsx_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP  = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_ADD  = 3'd3,
      OP_SUB  = 3'd4,
      OP_MUL  = 3'd5,
      OP_DIV  = 3'd6,
      OP_HALT = 3'd7
   } opcode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_LOAD = 1'b1
   } xstate_e;

   function automatic logic is_binary(opcode_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
   endfunction
endpackage

// File: rtl/zsx_alu.sv
module zsx_alu
   import zsx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] result,
   output logic              div_zero
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("zsx_alu: DATA_W must be at least 2");
      end
   endgenerate

   logic [2*DATA_W-1:0] product;

   always_comb begin
      product  = lhs * rhs;
      div_zero = (op == OP_DIV) && (rhs == '0);
      unique case (op)
         OP_ADD:  result = lhs + rhs;
         OP_SUB:  result = lhs - rhs;
         OP_MUL:  result = product[DATA_W-1:0];
         OP_DIV:  result = (rhs == '0) ? '0 : lhs / rhs;
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/zsx_stack.sv
module zsx_stack #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_en,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_en,
   input  logic              fold_en,
   input  logic [DATA_W-1:0] fold_data,
   output logic [DATA_W-1:0] top,
   output logic [DATA_W-1:0] second,
   output logic              full,
   output logic              empty,
   output logic              has_two
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("zsx_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] ent [DEPTH];
   logic [CNT_W-1:0]  count;
   logic [IDX_W-1:0]  top_idx;
   logic [IDX_W-1:0]  sec_idx;

   assign top_idx = IDX_W'(count - CNT_W'(1));
   assign sec_idx = IDX_W'(count - CNT_W'(2));
   assign top     = ent[top_idx];
   assign second  = ent[sec_idx];
   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign has_two = (count >= CNT_W'(2));

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (push_en) begin
         count <= count + CNT_W'(1);
      end else if (pop_en || fold_en) begin
         count <= count - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push_en && (count == CNT_W'(i))) begin
            ent[i] <= push_data;
         end else if (fold_en && (count == CNT_W'(i + 2))) begin
            ent[i] <= fold_data;
         end
      end
   end

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (rst)
      count <= CNT_W'(DEPTH));
   // R6
   no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
      push_en |-> !full);
   // R7
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (pop_en || fold_en) |-> !empty);
   // R4
   fold_depth_chk: assert property (@(posedge clk) disable iff (rst)
      fold_en |=> !full);
endmodule

// File: rtl/zstack_exec_unit.sv
module zstack_exec_unit
   import zsx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 8,
   localparam int INSTR_W = OPC_W + ADDR_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   output logic               instr_ready,
   input  logic [INSTR_W-1:0] instr_word,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd_en,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               mem_wr_en,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               halted,
   output logic               ovf_flag,
   output logic               unf_flag,
   output logic               dz_flag
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("zstack_exec_unit: ADDR_W must be at least 1");
      end
   endgenerate

   xstate_e           state;
   opcode_e           opc;
   logic              accept;
   logic              is_bin;
   logic              push_ok, pop_ok, bin_ok;
   logic              set_ovf, set_unf, set_dz;
   logic [DATA_W-1:0] top_w, sec_w, alu_res;
   logic              alu_dz;
   logic              st_full, st_empty, st_two;

   assign opc         = opcode_e'(instr_word[INSTR_W-1 -: OPC_W]);
   assign instr_ready = (state == ST_IDLE) && !halted;
   assign accept      = instr_valid && instr_ready;
   assign is_bin      = is_binary(opc);

   assign push_ok = accept && (opc == OP_PUSH) && !st_full;
   assign pop_ok  = accept && (opc == OP_POP) && !st_empty;
   assign bin_ok  = accept && is_bin && st_two;

   assign set_ovf = accept && (opc == OP_PUSH) && st_full;
   assign set_unf = accept && (((opc == OP_POP) && st_empty) || (is_bin && !st_two));
   assign set_dz  = bin_ok && alu_dz;

   assign mem_addr  = instr_word[ADDR_W-1:0];
   assign mem_rd_en = push_ok;
   assign mem_wr_en = pop_ok;
   assign mem_wdata = top_w;

   zsx_alu #(.DATA_W(DATA_W)) u_alu (
      .op       (opc),
      .lhs      (sec_w),
      .rhs      (top_w),
      .result   (alu_res),
      .div_zero (alu_dz)
   );

   zsx_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst       (rst),
      .push_en   (state == ST_LOAD),
      .push_data (mem_rdata),
      .pop_en    (pop_ok),
      .fold_en   (bin_ok),
      .fold_data (alu_res),
      .top       (top_w),
      .second    (sec_w),
      .full      (st_full),
      .empty     (st_empty),
      .has_two   (st_two)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         halted   <= 1'b0;
         ovf_flag <= 1'b0;
         unf_flag <= 1'b0;
         dz_flag  <= 1'b0;
      end else begin
         state <= push_ok ? ST_LOAD : ST_IDLE;
         if (accept && (opc == OP_HALT)) halted <= 1'b1;
         if (set_ovf) ovf_flag <= 1'b1;
         if (set_unf) unf_flag <= 1'b1;
         if (set_dz)  dz_flag  <= 1'b1;
      end
   end

   // R2
   load_wait_chk: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en |=> !instr_ready);
   // R2
   single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_en && mem_wr_en));
   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);
   // R8
   halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!mem_rd_en && !mem_wr_en && !instr_ready));
   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_flag |=> ovf_flag);
   // R10
   unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      unf_flag |=> unf_flag);
   // R5
   dz_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      dz_flag |=> dz_flag);
endmodule

// File: tb/test_zstack_exec_unit.sv
module test_zstack_exec_unit;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int DP = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          instr_valid = 1'b0;
   logic          instr_ready;
   logic [AW+2:0] instr_word = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd_en, mem_wr_en;
   logic [DW-1:0] mem_rdata = '0;
   logic [DW-1:0] mem_wdata;
   logic          halted, ovf_flag, unf_flag, dz_flag;

   logic [DW-1:0] dmem [256];
   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   zstack_exec_unit #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DP)) i_zstack_exec_unit (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
      .instr_word(instr_word), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
      .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
      .halted(halted), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .dz_flag(dz_flag));

   always @(posedge clk) begin
      if (mem_wr_en) dmem[mem_addr] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= dmem[mem_addr];
   end

   // opcodes: 0 nop, 1 load, 2 store, 3 add, 4 sub, 5 mul, 6 div, 7 halt
   // rows: {op, left, right, expected}
   localparam logic [50:0] VEC [10] = '{
      {3'd3, 16'd5,     16'd2,    16'd7},
      {3'd4, 16'd5,     16'd2,    16'd3},
      {3'd4, 16'd2,     16'd5,    16'hFFFD},
      {3'd3, 16'hFFFF,  16'd1,    16'd0},
      {3'd5, 16'd300,   16'd7,    16'd2100},
      {3'd5, 16'h0100,  16'h0100, 16'd0},
      {3'd5, 16'h1234,  16'h0010, 16'h2340},
      {3'd6, 16'd6,     16'd3,    16'd2},
      {3'd6, 16'd7,     16'd2,    16'd3},
      {3'd6, 16'd3,     16'd9,    16'd0}
   };

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [AW-1:0] a);
      @(negedge clk);
      while (!instr_ready) @(negedge clk);
      instr_word  = {op, a};
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      while (!instr_ready && !halted) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      instr_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) dmem[i] = 16'hA5A5;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(instr_ready && !halted && !ovf_flag && !unf_flag && !dz_flag, "R1",
          {halted, ovf_flag, unf_flag, dz_flag, instr_ready}, 32'h1);

      // R4 R5 vector table
      for (int v = 0; v < 10; v++) begin
         dmem[10] = VEC[v][47:32];
         dmem[11] = VEC[v][31:16];
         issue(3'd1, 8'd10);
         issue(3'd1, 8'd11);
         issue(VEC[v][50:48], 8'd0);
         issue(3'd2, 8'd12);
         @(negedge clk);
         chk(dmem[12] == VEC[v][15:0], (VEC[v][50:48] == 3'd6) ? "R5 quotient" : "R4 arith",
             dmem[12], VEC[v][15:0]);
      end
      chk(!ovf_flag && !unf_flag && !dz_flag, "R4 flags quiet",
          {ovf_flag, unf_flag, dz_flag}, 0);

      // R2 load timing
      dmem[20] = 16'h0BEE;
      @(negedge clk);
      instr_word = {3'd1, 8'd20};
      instr_valid = 1'b1;
      #1;
      chk(mem_rd_en && mem_addr == 8'd20, "R2 read strobe", {mem_rd_en, mem_addr}, {1'b1, 8'd20});
      @(negedge clk);
      instr_valid = 1'b0;
      chk(!instr_ready, "R2 ready low in wait", instr_ready, 0);
      @(negedge clk);
      chk(instr_ready, "R2 ready back", instr_ready, 1);
      // R3 store
      @(negedge clk);
      instr_word = {3'd2, 8'd21};
      instr_valid = 1'b1;
      #1;
      chk(mem_wr_en && mem_wdata == 16'h0BEE && mem_addr == 8'd21, "R3 write strobe",
          mem_wdata, 16'h0BEE);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(dmem[21] == 16'h0BEE, "R3 stored", dmem[21], 16'h0BEE);

      // R7 store on empty: no write, flag set
      dmem[30] = 16'h7777;
      issue(3'd2, 8'd30);
      chk(unf_flag && dmem[30] == 16'h7777, "R7 empty store", {unf_flag, dmem[30]}, {1'b1, 16'h7777});
      // R7 binary with one entry
      do_reset();
      dmem[31] = 16'd9;
      issue(3'd1, 8'd31);
      issue(3'd3, 8'd0);
      chk(unf_flag, "R7 short add flag", unf_flag, 1);
      issue(3'd2, 8'd32);
      @(negedge clk);
      chk(dmem[32] == 16'd9, "R7 stack unchanged", dmem[32], 9);

      // R6 overflow
      do_reset();
      for (int k = 0; k < DP; k++) begin
         dmem[40 + k] = 16'(100 + k);
         issue(3'd1, 8'(40 + k));
      end
      chk(!ovf_flag, "R6 full no flag", ovf_flag, 0);
      dmem[60] = 16'hDEAD;
      @(negedge clk);
      instr_word = {3'd1, 8'd60};
      instr_valid = 1'b1;
      #1;
      chk(!mem_rd_en, "R6 no read when full", mem_rd_en, 0);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(ovf_flag, "R6 flag", ovf_flag, 1);
      for (int k = DP - 1; k >= 0; k--) begin
         issue(3'd2, 8'd70);
         @(negedge clk);
         chk(dmem[70] == 16'(100 + k), "R6 drain order", dmem[70], 16'(100 + k));
      end
      chk(!unf_flag && ovf_flag, "R10 flag sticky", {ovf_flag, unf_flag}, 2'b10);

      // R5 divide by zero
      do_reset();
      dmem[80] = 16'd5;
      dmem[81] = 16'd0;
      issue(3'd1, 8'd80);
      issue(3'd1, 8'd81);
      issue(3'd6, 8'd0);
      chk(dz_flag, "R5 dz flag", dz_flag, 1);
      issue(3'd2, 8'd82);
      @(negedge clk);
      chk(dmem[82] == 16'd0, "R5 dz result", dmem[82], 0);

      // R10 no-op
      do_reset();
      dmem[90] = 16'd11;
      issue(3'd1, 8'd90);
      issue(3'd0, 8'd0);
      issue(3'd2, 8'd91);
      @(negedge clk);
      chk(dmem[91] == 16'd11 && !unf_flag && !ovf_flag && !dz_flag, "R10 nop", dmem[91], 11);

      // R9 postfix program
      dmem[100] = 16'd3; dmem[101] = 16'd4; dmem[102] = 16'd5; dmem[103] = 16'd6;
      issue(3'd1, 8'd100); issue(3'd1, 8'd101); issue(3'd5, 8'd0);
      issue(3'd1, 8'd102); issue(3'd1, 8'd103); issue(3'd5, 8'd0);
      issue(3'd3, 8'd0);   issue(3'd2, 8'd104);
      @(negedge clk);
      chk(dmem[104] == 16'd42, "R9 program", dmem[104], 42);

      // R8 halt
      issue(3'd7, 8'd0);
      chk(halted && !instr_ready, "R8 halted", {halted, instr_ready}, 2'b10);
      instr_word = {3'd1, 8'd100};
      instr_valid = 1'b1;
      for (int c = 0; c < 4; c++) begin
         #1;
         chk(!mem_rd_en && !instr_ready && halted, "R8 frozen", {mem_rd_en, instr_ready}, 0);
         @(negedge clk);
      end
      instr_valid = 1'b0;
      do_reset();
      @(negedge clk);
      chk(!halted && instr_ready && !dz_flag, "R1 reset clears halt", {halted, instr_ready}, 2'b01);

      done = 1'b1;
   end

   initial begin
      for (int t = 0; t < 20000; t++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule